// File: doc/BRIEF.md
# Timer Tick Divider and Pulse Generators

This block turns a reference clock qualifier into the time bases used by the timers around it. A one-cycle `ref_en_i` strobe marks each period of the 19.2 MHz reference. A programmable divider counts those strobes and produces a common tick. When the divider is programmed with 191 the ratio is 192, so the common tick runs at 100 kHz and each tick stands for 10 µs.

Three pulse channels count common ticks independently. Each channel emits a one-cycle pulse each time its count reaches the tick total chosen by its own 3-bit granularity code. Timers elsewhere in the chip, such as aggregation and head-of-line timers, use these pulses as their time base.

Two 32-bit configuration words are written through a simple write strobe with a select bit. One word sets the divide value and the enable. The other word sets the three granularity codes. The divide value must only be changed while the divider is disabled: software first writes the enable as 0, then writes the new value with the enable set.

Top module: `tick_pulse_gen`

## Requirements
- R1: After reset the divider is disabled, all three granularity codes are 0, and `base_tick_o` and `pulse_o` stay low until the divider is enabled.
- R2: A write with `cfg_sel_i`=0 loads the divide value from `cfg_wdata_i[8:0]` and the enable from `cfg_wdata_i[31]`. Bits 30:9 are ignored.
- R3: While the divider is enabled, `base_tick_o` is a one-cycle pulse. It occurs once every (value+1) cycles in which `ref_en_i` is high, one cycle after the last of those cycles.
- R4: While the divider is disabled, `base_tick_o` and `pulse_o` stay low and the divider and channel counts are cleared. After re-enabling, the first tick follows exactly value+1 qualified reference cycles.
- R5: A write with `cfg_sel_i`=1 loads the code for channel 0 from bits 2:0, channel 1 from bits 5:3 and channel 2 from bits 8:6. Other bits are ignored.
- R6: The granularity codes map to tick totals as follows: 0→1, 1→2, 2→5, 3→10, 4→100, 5→1000, 6→10000, 7→65535. With 10 µs ticks these are 10 µs, 20 µs, 50 µs, 100 µs, 1 ms, 10 ms, 100 ms and 655.35 ms.
- R7: Each channel pulses for one cycle, in the cycle after the common tick that completes its tick total, and then counts again from zero. The three channels run concurrently.
- R8: A write that changes a channel's code restarts that channel from zero and discards a tick consumed on the write edge. Channels whose code is unchanged keep their count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en_i | input | 1 | One-cycle qualifier marking each reference clock period |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the divider word, 1 selects the granularity word |
| cfg_wdata_i | input | 32 | Configuration write data |
| base_tick_o | output | 1 | Common tick, one cycle wide |
| pulse_o | output | 3 | One-cycle pulses of channels 2..0 |

## Verification
The in-RTL properties assume that software honours the programming rule: the divide value changes only in the same write that sets the enable, starting from a disabled divider. Under that rule the divider count can never exceed the programmed value. The stimulus follows this rule in every phase. Each reprogramming of the divider is a disabling write followed by an enabling write that carries the new value. Granularity codes, in contrast, are rewritten at random points while ticks are flowing, so the property and the bench both see restarts landing on tick edges. The reference strobe is driven either continuously high or at random, and the upper bits of both configuration words carry random values.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int unsigned GRAN_W     = 3;
  localparam int unsigned TICK_CNT_W = 16;

  typedef logic [GRAN_W-1:0]     gran_code_t;
  typedef logic [TICK_CNT_W-1:0] tick_cnt_t;

  // Number of common ticks (10 us each at the nominal ratio) per code
  function automatic tick_cnt_t gran_ticks(input gran_code_t code);
    tick_cnt_t n;
    case (code)
      3'd0:    n = 16'd1;
      3'd1:    n = 16'd2;
      3'd2:    n = 16'd5;
      3'd3:    n = 16'd10;
      3'd4:    n = 16'd100;
      3'd5:    n = 16'd1000;
      3'd6:    n = 16'd10000;
      default: n = 16'd65535;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIV_W      = 9,
  parameter int unsigned DIV_EN_BIT = 31,
  parameter int unsigned NUM_CH     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic                           sel_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DIV_W-1:0]               div_val_o,
  output logic                           div_en_o,
  output logic [NUM_CH-1:0][GRAN_W-1:0]  codes_o,
  output logic [NUM_CH-1:0]              restart_o
);

  localparam int unsigned GRAN_FIELD_W = NUM_CH * GRAN_W;

  logic                          wr_div, wr_gran;
  logic [DIV_W-1:0]              div_val_q, div_val_d;
  logic                          div_en_q, div_en_d;
  logic [NUM_CH-1:0][GRAN_W-1:0] codes_q, codes_d;
  logic                          unused_wdata;

  assign wr_div       = wr_i && !sel_i;
  assign wr_gran      = wr_i && sel_i;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    div_val_d = div_val_q;
    div_en_d  = div_en_q;
    if (wr_div) begin
      div_val_d = wdata_i[DIV_W-1:0];
      div_en_d  = wdata_i[DIV_EN_BIT];
    end
  end

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_field
      always_comb begin
        codes_d[ch] = codes_q[ch];
        if (wr_gran) codes_d[ch] = wdata_i[ch*GRAN_W +: GRAN_W];
      end
      // restart is evaluated on the write edge itself
      assign restart_o[ch] = wr_gran && (wdata_i[ch*GRAN_W +: GRAN_W] != codes_q[ch]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val_q <= '0;
      div_en_q  <= 1'b0;
      codes_q   <= '0;
    end else begin
      div_val_q <= div_val_d;
      div_en_q  <= div_en_d;
      codes_q   <= codes_d;
    end
  end

  assign div_val_o = div_val_q;
  assign div_en_o  = div_en_q;
  assign codes_o   = codes_q;

  // Divider word only changes on a write that selects it
  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> ($stable(div_val_o) && $stable(div_en_o)));

  // Granularity word only changes on a write that selects it
  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gran |=> $stable(codes_o));

  // Sanity on the field width against the data word
  initial begin
    if (GRAN_FIELD_W > DATA_W || DIV_W > DATA_W || DIV_EN_BIT >= DATA_W)
      $error("tpg_cfg_regs: field layout does not fit the data word");
  end

endmodule

// File: rtl/tpg_divider.sv
module tpg_divider #(
  parameter int unsigned DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] val_i,
  input  logic             ref_en_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             wrap;

  // >= keeps the count bounded even if the value shrinks
  assign wrap = (cnt_q >= val_i);

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
    end else if (ref_en_i) begin
      if (wrap) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = DIV_W'(cnt_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  p_cnt_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= val_i));

  p_tick_needs_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(ref_en_i && en_i));

endmodule

// File: rtl/tpg_pulse_chan.sv
module tpg_pulse_chan
  import tpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       restart_i,
  input  gran_code_t code_i,
  output logic       pulse_o
);

  tick_cnt_t pcnt_q, pcnt_d;
  tick_cnt_t limit;
  logic      pulse_q, pulse_d;

  assign limit = gran_ticks(code_i);

  always_comb begin
    pcnt_d  = pcnt_q;
    pulse_d = 1'b0;
    if (!en_i || restart_i) begin
      pcnt_d = '0;
    end else if (tick_i) begin
      if (pcnt_q >= limit - 16'd1) begin
        pcnt_d  = '0;
        pulse_d = 1'b1;
      end else begin
        pcnt_d = pcnt_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pcnt_q  <= pcnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  p_pulse_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(tick_i));

  p_pcnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q < limit);

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (pcnt_q == '0 && !pulse_q));

  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pcnt_q == '0));

endmodule

// File: rtl/tick_pulse_gen.sv
module tick_pulse_gen
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DIV_W      = 9,
  parameter int unsigned DIV_EN_BIT = 31,
  parameter int unsigned NUM_CH     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              base_tick_o,
  output logic [NUM_CH-1:0] pulse_o
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]        rst_sync_q;
  logic                          rst_n_int;
  logic [DIV_W-1:0]              div_val;
  logic                          div_en;
  logic [NUM_CH-1:0][GRAN_W-1:0] codes;
  logic [NUM_CH-1:0]             restart;
  logic                          tick_raw;
  logic [NUM_CH-1:0]             pulse_raw;

  // reset asserts at once, releases after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  tpg_cfg_regs #(
    .DATA_W     (DATA_W),
    .DIV_W      (DIV_W),
    .DIV_EN_BIT (DIV_EN_BIT),
    .NUM_CH     (NUM_CH)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_i      (cfg_wr_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .div_val_o (div_val),
    .div_en_o  (div_en),
    .codes_o   (codes),
    .restart_o (restart)
  );

  tpg_divider #(
    .DIV_W (DIV_W)
  ) i_div (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .en_i     (div_en),
    .val_i    (div_val),
    .ref_en_i (ref_en_i),
    .tick_o   (tick_raw)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      tpg_pulse_chan i_chan (
        .clk       (clk),
        .rst_n     (rst_n_int),
        .en_i      (div_en),
        .tick_i    (tick_raw),
        .restart_i (restart[ch]),
        .code_i    (codes[ch]),
        .pulse_o   (pulse_raw[ch])
      );
    end
  endgenerate

  // Outputs are silenced in the cycle the enable drops
  assign base_tick_o = tick_raw & div_en;
  assign pulse_o     = pulse_raw & {NUM_CH{div_en}};

  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n_int |=> (!base_tick_o && pulse_o == '0));

endmodule

// File: tb/test_tick_pulse_gen.sv
`timescale 1ns/1ps
module test_tick_pulse_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_en;
  logic        cfg_wr;
  logic        cfg_sel;
  logic [31:0] cfg_wdata;
  logic        base_tick;
  logic [2:0]  pulse;

  always #2.5 clk = ~clk;

  tick_pulse_gen i_tick_pulse_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_en_i    (ref_en),
    .cfg_wr_i    (cfg_wr),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .base_tick_o (base_tick),
    .pulse_o     (pulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  bit         mon_on = 0;
  bit         ref_rand = 0;
  bit         en_m = 0;
  int         d_m = 0;
  int         refcnt = 0;
  int         ticks_since [3];
  logic [2:0] code_m [3];
  int         pulses_seen [3];
  int         quiet_viol = 0;
  bit         pend_div = 0;
  bit         pd_en;
  int         pd_val;
  bit         pend_gran = 0;
  logic [2:0] pg_code [3];

  function automatic int exp_ticks(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 5;
      3'd3: return 10;
      3'd4: return 100;
      3'd5: return 1000;
      3'd6: return 10000;
      default: return 65535;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor and reference-strobe driver, away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (en_m && ref_en) refcnt++;
      if (!en_m && (base_tick || pulse != 3'b000)) quiet_viol++;
      if (base_tick) begin
        chk(refcnt == d_m + 1, "R3 tick interval", refcnt, d_m + 1);
        refcnt = 0;
      end else if (en_m && refcnt > d_m + 1) begin
        chk(1'b0, "R3 missing tick", refcnt, d_m + 1);
        refcnt = 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (pulse[i]) begin
          chk(ticks_since[i] == exp_ticks(code_m[i]), "R6/R7 pulse interval",
              ticks_since[i], exp_ticks(code_m[i]));
          ticks_since[i] = 0;
          pulses_seen[i]++;
        end
      end
      if (pend_div) begin
        en_m = pd_en; d_m = pd_val; refcnt = 0;
        for (int i = 0; i < 3; i++) ticks_since[i] = 0;
        pend_div = 0;
      end
      if (pend_gran) begin
        for (int i = 0; i < 3; i++) begin
          if (pg_code[i] != code_m[i]) ticks_since[i] = 0;   // R8 restart
          code_m[i] = pg_code[i];
        end
        pend_gran = 0;
      end
      for (int i = 0; i < 3; i++) begin
        if (base_tick) ticks_since[i]++;
        if (ticks_since[i] > exp_ticks(code_m[i])) begin
          chk(1'b0, "R7 missing pulse", ticks_since[i], exp_ticks(code_m[i]));
          ticks_since[i] = 0;
        end
      end
    end
    ref_en = ref_rand ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic cfg_write(input bit sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk);
    #1;
    cfg_wr = 1'b0;
    if (!sel) begin
      pend_div = 1; pd_en = data[31]; pd_val = int'(data[8:0]);
    end else begin
      pend_gran = 1;
      for (int i = 0; i < 3; i++) pg_code[i] = data[i*3 +: 3];
    end
  endtask

  function automatic logic [31:0] div_word(input bit en, input int val);
    logic [31:0] w;
    w = $urandom;
    w[31] = en;
    w[8:0] = 9'(val);
    return w;
  endfunction

  function automatic logic [31:0] gran_word(input logic [2:0] c0, input logic [2:0] c1,
                                            input logic [2:0] c2);
    logic [31:0] w;
    w = $urandom;
    w[8:0] = {c2, c1, c0};
    return w;
  endfunction

  task automatic clear_seen();
    for (int i = 0; i < 3; i++) pulses_seen[i] = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Watchdog
  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ref_en = 1'b1; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    for (int i = 0; i < 3; i++) begin
      ticks_since[i] = 0; code_m[i] = 3'd0; pulses_seen[i] = 0;
    end
    run(5);
    rst_n = 1'b1;
    run(4);
    // R1: quiet after reset, no enable yet
    chk(base_tick == 1'b0, "R1 tick after reset", int'(base_tick), 0);
    chk(pulse == 3'b000, "R1 pulses after reset", int'(pulse), 0);
    run(50);
    chk(base_tick == 1'b0 && pulse == 3'b000, "R1 idle while disabled", int'(pulse), 0);
    mon_on = 1;

    // R2/R1: nominal ratio 192, reset codes 0 pulse on every tick
    clear_seen();
    cfg_write(1'b0, div_word(1'b1, 191));
    run(1000);
    for (int i = 0; i < 3; i++)
      chk(pulses_seen[i] == 5, "R2 ratio 192 pulses with reset code 0", pulses_seen[i], 5);

    // R4: disable, nothing comes out
    cfg_write(1'b0, div_word(1'b0, 191));
    quiet_viol = 0;
    run(400);
    chk(quiet_viol == 0, "R4 quiet while disabled", quiet_viol, 0);

    // R4: re-enable with new value and random strobe
    ref_rand = 1;
    cfg_write(1'b0, div_word(1'b1, 3));
    run(600);
    ref_rand = 0;

    // R5/R6: codes 4,5,6 on channels 0,1,2 at one tick per cycle
    cfg_write(1'b0, div_word(1'b0, 3));
    cfg_write(1'b0, div_word(1'b1, 0));
    cfg_write(1'b1, gran_word(3'd4, 3'd5, 3'd6));
    clear_seen();
    run(20100);
    chk(pulses_seen[0] >= 200, "R5 channel 0 field", pulses_seen[0], 200);
    chk(pulses_seen[1] >= 20,  "R5 channel 1 field", pulses_seen[1], 20);
    chk(pulses_seen[2] == 2,   "R5 channel 2 field", pulses_seen[2], 2);

    // R6: longest code on channel 2
    cfg_write(1'b1, gran_word(3'd0, 3'd1, 3'd7));
    clear_seen();
    run(65600);
    chk(pulses_seen[2] == 1, "R6 code 7 span", pulses_seen[2], 1);

    // R8: change only channel 0 mid-count
    cfg_write(1'b1, gran_word(3'd3, 3'd3, 3'd3));
    run(23);
    clear_seen();
    cfg_write(1'b1, gran_word(3'd2, 3'd3, 3'd3));
    run(200);
    chk(pulses_seen[0] >= 39, "R8 restarted channel runs", pulses_seen[0], 39);
    chk(pulses_seen[1] >= 19, "R8 untouched channel runs", pulses_seen[1], 19);

    // Random phase: reprogram divider by protocol, rewrite codes anywhere
    for (int it = 0; it < 24; it++) begin
      int sel_op;
      sel_op = $urandom_range(0, 2);
      ref_rand = 1'($urandom_range(0, 1));
      if (sel_op == 0) begin
        cfg_write(1'b0, div_word(1'b0, int'($urandom_range(0, 511))));
        run($urandom_range(1, 20));
        cfg_write(1'b0, div_word(1'b1, int'($urandom_range(0, 6))));
      end else begin
        cfg_write(1'b1, gran_word(3'($urandom_range(0, 3)), 3'($urandom_range(0, 3)),
                                  3'($urandom_range(0, 3))));
      end
      run($urandom_range(200, 1200));
    end
    cfg_write(1'b0, div_word(1'b0, 0));
    quiet_viol = 0;
    run(100);
    chk(quiet_viol == 0, "R4 quiet after final disable", quiet_viol, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule